// File: doc/BRIEF.md
# Pipelined Parallel-Request Crossbar Arbiter

This block computes crossbar matchings for an N-port switch, with K matching allocators arranged as a pipeline. Each allocator holds a partial matching. The deeper the allocator sits in the pipeline, the more iterations its matching has been through. In every time slot, every allocator receives its own request matrix from an upstream filter. Each allocator then runs one request-grant-accept iteration, and that iteration may only join an input and an output that are both still free in that allocator's matching.

At the end of the slot, the deepest allocator hands its matching to a registered grant output. Every other matching moves one position deeper. The shallowest position starts again with an empty matching. Because the deepest allocator also takes fresh requests, a request seen by an idle arbiter is granted in the same slot and appears one clock later. No pipeline fill delay applies. Every clock cycle is one slot. Each allocator position keeps a round-robin grant pointer for each output and a round-robin accept pointer for each input.

Top module: `pipe_xbar_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the grant matrix is all zero, every carried matching is empty and every pointer is zero.
- R2: Bit i*N+j of `grant` means input i is connected to output j. Request bit k*N*N+i*N+j means input i asks output j at allocator position k, where position K-1 is the deepest. The grant matrix seen after a clock edge is the matching that the deepest position produced in that slot.
- R3: When the deepest position carries an empty matching and receives a request (i,j) with no other requests, `grant` holds exactly bit (i,j) one cycle later.
- R4: An iteration adds an edge only where both its input row and its output column are unmatched in the carried matching. Edges that have already been carried are always kept.
- R5: `grant` never holds more than one bit in any row or any column.
- R6: Position 0 starts each slot from an empty matching. A request given only to position 0 in one slot, followed by idle slots, appears in `grant` exactly K cycles later and lasts for only one cycle.
- R7: In its grant step, each free output picks the first free requesting input at or after its grant pointer. When an edge is formed, that output's pointer moves to one past the chosen input, modulo N.
- R8: In its accept step, each free input picks the first granting output at or after its accept pointer. When an edge is formed, that input's pointer moves to one past the chosen output, modulo N.
- R9: When every position requests every (i,j) in every slot, each grant after 2N+K slots is a full permutation with N edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | K*N*N | Request matrices, one N*N slice for each allocator position |
| grant | output | N*N | Registered matching emitted by the deepest position |

## Verification
A carried matching that is corrupted shows up at `grant` as soon as that matching reaches the deepest position, at most K cycles later. It appears either as extra or missing edges, or as a row or column holding two bits. A pointer that drifts does not show up until contention happens. It then shows as the wrong winner, one cycle after a slot in which several inputs compete for one output at the deepest position. The bench therefore steps a model of every position and its pointers alongside the design, and compares every grant cycle by cycle.

// File: rtl/pipe_xbar_arb.sv
module pipe_xbar_arb #(
  parameter int N = 4,
  parameter int K = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [K*N*N-1:0] req,
  output logic [N*N-1:0]   grant
);
  localparam int NN = N * N;
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [K-1:1][NN-1:0] mreg;
  logic [NN-1:0] nxt_m [K];

  for (genvar k = 0; k < K; k++) begin : g_stage
    logic [NN-1:0] cur, rq, gs, ed;
    logic [N-1:0]  ifree, ofree;
    logic [PW-1:0] gp [N];
    logic [PW-1:0] ap [N];

    if (k == 0) begin : g_empty
      assign cur = '0;
    end else begin : g_carry
      assign cur = mreg[k];
    end
    assign rq = req[k*NN +: NN];

    always_comb begin
      logic found;
      int idx;
      for (int i = 0; i < N; i++) ifree[i] = ~|cur[i*N +: N];
      for (int j = 0; j < N; j++) begin
        ofree[j] = 1'b1;
        for (int i = 0; i < N; i++) if (cur[i*N+j]) ofree[j] = 1'b0;
      end
      gs = '0;
      for (int j = 0; j < N; j++) begin
        found = 1'b0;
        for (int off = 0; off < N; off++) begin
          idx = (int'(gp[j]) + off) % N;
          if (!found && ofree[j] && ifree[idx] && rq[idx*N+j]) begin
            gs[idx*N+j] = 1'b1;
            found = 1'b1;
          end
        end
      end
      ed = '0;
      for (int i = 0; i < N; i++) begin
        found = 1'b0;
        for (int off = 0; off < N; off++) begin
          idx = (int'(ap[i]) + off) % N;
          if (!found && gs[i*N+idx]) begin
            ed[i*N+idx] = 1'b1;
            found = 1'b1;
          end
        end
      end
    end

    assign nxt_m[k] = cur | ed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int p = 0; p < N; p++) begin
          gp[p] <= '0;
          ap[p] <= '0;
        end
      end else begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < N; j++)
            if (ed[i*N+j]) begin
              gp[j] <= PW'((i + 1) % N);
              ap[i] <= PW'((j + 1) % N);
            end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mreg  <= '0;
      grant <= '0;
    end else begin
      for (int k = 1; k < K; k++) mreg[k] <= nxt_m[k-1];
      grant <= nxt_m[K-1];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    logic [N-1:0] colv;
    always_comb for (int r = 0; r < N; r++) colv[r] = grant[r*N+i];
    // R5
    row_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant[i*N +: N]) <= 1);
    // R5
    col_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(colv) <= 1);
  end

  // R4
  keep_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (grant & $past(mreg[K-1])) == $past(mreg[K-1]));

  for (genvar k = 2; k < K; k++) begin : g_keep
    // R4
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mreg[k] & $past(mreg[k-1])) == $past(mreg[k-1]));
  end

  // R3
  low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreg[K-1] == '0 && req[(K-1)*NN +: NN] != '0) |=> grant != '0);

  // R6
  fresh_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mreg[1] & ~$past(req[0 +: NN])) == '0);
endmodule

// File: tb/tb_pipe_xbar_arb.sv
module tb_pipe_xbar_arb;
  localparam int N  = 4;
  localparam int K  = 3;
  localparam int NN = N * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [K*NN-1:0] req = '0;
  logic [NN-1:0] grant;

  int checks = 0;
  int errors = 0;

  bit mm [K][N][N];
  int gpm [K][N];
  int apm [K][N];
  logic [NN-1:0] expv;

  pipe_xbar_arb #(.N(N), .K(K)) dut (.clk(clk), .rst_n(rst_n), .req(req), .grant(grant));

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string tag, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int rb(int k, int i, int j);
    return k*NN + i*N + j;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < K; k++)
      for (int a = 0; a < N; a++) begin
        gpm[k][a] = 0; apm[k][a] = 0;
        for (int b = 0; b < N; b++) mm[k][a][b] = 0;
      end
  endtask

  task automatic model_step(input logic [K*NN-1:0] r);
    bit nx [K][N][N];
    bit gsel [N][N];
    bit rowbusy [N];
    bit colbusy [N];
    for (int k = 0; k < K; k++) begin
      for (int a = 0; a < N; a++) begin
        rowbusy[a] = 0; colbusy[a] = 0;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          nx[k][i][j] = (k == 0) ? 1'b0 : mm[k][i][j];
          gsel[i][j] = 0;
          if (nx[k][i][j]) begin rowbusy[i] = 1; colbusy[j] = 1; end
        end
      for (int j = 0; j < N; j++) begin
        if (colbusy[j]) continue;
        for (int d = 0; d < N; d++) begin
          int i = (gpm[k][j] + d) % N;
          if (!rowbusy[i] && r[rb(k, i, j)]) begin gsel[i][j] = 1; break; end
        end
      end
      for (int i = 0; i < N; i++) begin
        for (int d = 0; d < N; d++) begin
          int j = (apm[k][i] + d) % N;
          if (gsel[i][j]) begin
            nx[k][i][j] = 1;
            gpm[k][j] = (i + 1) % N;
            apm[k][i] = (j + 1) % N;
            break;
          end
        end
      end
    end
    for (int k = K-1; k >= 1; k--)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) mm[k][i][j] = nx[k-1][i][j];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) expv[i*N+j] = nx[K-1][i][j];
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    model_clear();
    expv = '0;
    repeat (2) @(negedge clk);
    check("R1 grant in reset", grant, '0);
    rst_n = 1'b1;
  endtask

  task automatic slot(input logic [K*NN-1:0] r);
    req = r;
    model_step(r);
    @(negedge clk);
    check("R2 grant vs model", grant, expv);
  endtask

  function automatic bit is_matching(input logic [NN-1:0] g);
    for (int a = 0; a < N; a++) begin
      int rc = 0, cc = 0;
      for (int b = 0; b < N; b++) begin
        rc += g[a*N+b]; cc += g[b*N+a];
      end
      if (rc > 1 || cc > 1) return 0;
    end
    return 1;
  endfunction

  initial begin
    logic [K*NN-1:0] r;
    logic [NN-1:0] e;
    void'($urandom(32'd1234));

    do_reset();
    @(negedge clk);
    check("R1 grant after reset", grant, '0);

    // R3: idle arbiter, deepest position only
    r = '0; r[rb(K-1, 2, 1)] = 1'b1;
    slot(r);
    e = '0; e[2*N+1] = 1'b1;
    check("R3 immediate grant", grant, e);
    slot('0);
    check("R3 grant clears", grant, '0);

    // R6: request enters at position 0, appears K cycles later
    do_reset();
    r = '0; r[rb(0, 1, 3)] = 1'b1;
    slot(r);
    for (int t = 1; t < K; t++) begin
      check("R6 not yet emitted", grant, '0);
      slot('0);
    end
    e = '0; e[1*N+3] = 1'b1;
    check("R6 emitted after K", grant, e);
    slot('0);
    check("R6 one cycle only", grant, '0);

    // R4: carried edge blocks its row and column
    do_reset();
    r = '0; r[rb(0, 0, 0)] = 1'b1;
    slot(r);
    r = '0; r[rb(1, 0, 1)] = 1'b1; r[rb(1, 2, 0)] = 1'b1; r[rb(1, 2, 2)] = 1'b1;
    slot(r);
    slot('0);
    e = '0; e[0] = 1'b1; e[2*N+2] = 1'b1;
    check("R4 only free ports join", grant, e);

    // R7: all inputs want output 0 at the deepest position
    do_reset();
    r = '0;
    for (int i = 0; i < N; i++) r[rb(K-1, i, 0)] = 1'b1;
    for (int t = 0; t < 3; t++) begin
      slot(r);
      e = '0; e[t*N+0] = 1'b1;
      check("R7 grant pointer rotation", grant, e);
    end

    // R8: input 0 wants every output
    do_reset();
    r = '0;
    for (int j = 0; j < N; j++) r[rb(K-1, 0, j)] = 1'b1;
    for (int t = 0; t < 3; t++) begin
      slot(r);
      e = '0; e[t] = 1'b1;
      check("R8 accept pointer rotation", grant, e);
    end

    // R9: saturated uniform load
    do_reset();
    for (int t = 0; t < 2*N + K + 8; t++) begin
      slot('1);
      if (t >= 2*N + K) begin
        checks++;
        if ($countones(grant) != N) begin
          errors++;
          $display("FAIL R9 full permutation: actual=%0d expected=%0d", $countones(grant), N);
        end
      end
    end

    // R2/R5 random load of varying density
    do_reset();
    for (int t = 0; t < 400; t++) begin
      int dens = (t < 200) ? 3 : 40;
      for (int b = 0; b < K*NN; b++) r[b] = (($urandom % 100) < dens);
      slot(r);
      checks++;
      if (!is_matching(grant)) begin
        errors++;
        $display("FAIL R5 not a matching: actual=%h expected=one bit per row and column", grant);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule